// File: doc/BRIEF.md
# DMA Channel Register Set

This block holds the control/status word and the address registers of a single DMA channel, behind a register port that only honours full 32-bit accesses. Software programs a current pointer, a limit, a reload pair (start and stop) and an initial-buffer word. It then starts the channel by writing one-shot command bits into the control word. Those command bits do not store as written. Each one sets or clears a separate sticky status bit.

A small engine steps the current pointer by one word on each transfer strobe while the channel is enabled. When the pointer reaches the limit, the engine latches a snapshot of the four address registers and raises completion, which also drives the interrupt. If a chain update was armed, the engine instead reloads the pointer and limit from start and stop and keeps running.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: A control-word write with bit 16 set sets the enable status, which reads back at bit 24.
- R3: A control-word write with bit 17 set arms chain update, which reads back at bit 25.
- R4: A control-word write with bit 18 set sets the device-to-memory direction, which reads back at bit 18. A write with bit 18 clear leaves the direction unchanged.
- R5: A control-word write with bit 19 set clears the complete status (read at bit 27), and irq_o falls with it.
- R6: A control-word write with bit 20 set clears complete, chain update, enable and direction together. It takes precedence over the set commands in the same write.
- R7: The read/write registers sit at these offsets: next 0x4000, limit 0x4004, start 0x4008, stop 0x400C, initial buffer 0x4200. The snapshots of next, limit, start and stop sit at 0x3FF0, 0x3FF4, 0x3FF8 and 0x3FFC; they are read-only and ignore writes.
- R8: An access whose byte enables are not all set neither writes nor returns data (rdata_o is zero). An unmapped offset reads zero and ignores writes.
- R9: While enable is set, each transfer strobe adds 4 to next. With enable clear, a strobe changes nothing.
- R10: A strobe that brings next equal to limit sets complete and clears enable. It copies next, limit, start and stop into the snapshots and raises irq_o, which follows complete.
- R11: If chain update is armed at completion, next reloads from start and limit from stop. Chain update clears, enable stays set and complete is still set.
- R12: When a completion and a clear-complete command fall in the same cycle, complete stays set. A bus write to next in the same cycle as a strobe leaves the written value.
- R13: The size register at 0x4204 is read-only and returns limit minus next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; only all-ones is honoured |
| addr_i | input | 15 | Byte offset within the channel |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on the request |
| xfer_i | input | 1 | Transfer strobe, one word per cycle high |
| irq_o | output | 1 | Completion interrupt (level) |

## Verification
The engine's end-of-buffer event and a software write to the control word can land on the same clock edge. The same holds for a strobe and a software write to the pointer. The bench provokes each collision by raising the transfer strobe in the same cycle as the bus write. For the first case it checks that the completion is not lost to a simultaneous clear-complete, with enable still dropped. For the second it checks that the written pointer replaces the incremented one.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned OFS_W = 15;

  localparam logic [OFS_W-1:0] OFS_CTRL     = 15'h0000;
  localparam logic [OFS_W-1:0] OFS_SNAP_NXT = 15'h3FF0;
  localparam logic [OFS_W-1:0] OFS_SNAP_LIM = 15'h3FF4;
  localparam logic [OFS_W-1:0] OFS_SNAP_BEG = 15'h3FF8;
  localparam logic [OFS_W-1:0] OFS_SNAP_END = 15'h3FFC;
  localparam logic [OFS_W-1:0] OFS_NXT      = 15'h4000;
  localparam logic [OFS_W-1:0] OFS_LIM      = 15'h4004;
  localparam logic [OFS_W-1:0] OFS_BEG      = 15'h4008;
  localparam logic [OFS_W-1:0] OFS_END      = 15'h400C;
  localparam logic [OFS_W-1:0] OFS_INIT     = 15'h4200;
  localparam logic [OFS_W-1:0] OFS_SIZE     = 15'h4204;

  // command bit positions in a control-word write
  localparam int unsigned CMD_SET_EN  = 16;
  localparam int unsigned CMD_SET_UPD = 17;
  localparam int unsigned CMD_SET_DIR = 18;
  localparam int unsigned CMD_CLR_CMP = 19;
  localparam int unsigned CMD_RST     = 20;

  // status bit positions in a control-word read
  localparam int unsigned STS_DIR = 18;
  localparam int unsigned STS_EN  = 24;
  localparam int unsigned STS_UPD = 25;
  localparam int unsigned STS_CMP = 27;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_NXT, SEL_LIM, SEL_BEG, SEL_END, SEL_INIT,
    SEL_SIZE, SEL_SNAP_NXT, SEL_SNAP_LIM, SEL_SNAP_BEG, SEL_SNAP_END
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic upd;
    logic dir;
    logic cmp;
  } ctrl_sts_t;

  typedef struct packed {
    logic set_en;
    logic set_upd;
    logic set_dir;
    logic clr_cmp;
    logic rst;
  } ctrl_cmd_t;
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
  import dma_chan_pkg::*;
#(
  parameter int unsigned BE_W = 4
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [OFS_W-1:0] addr_i,
  output reg_sel_e         sel_o,
  output logic             wr_o,
  output logic             rd_o
);
  logic     full_word;
  reg_sel_e map_sel;

  assign full_word = &be_i;

  always_comb begin
    unique case (addr_i)
      OFS_CTRL:     map_sel = SEL_CTRL;
      OFS_NXT:      map_sel = SEL_NXT;
      OFS_LIM:      map_sel = SEL_LIM;
      OFS_BEG:      map_sel = SEL_BEG;
      OFS_END:      map_sel = SEL_END;
      OFS_INIT:     map_sel = SEL_INIT;
      OFS_SIZE:     map_sel = SEL_SIZE;
      OFS_SNAP_NXT: map_sel = SEL_SNAP_NXT;
      OFS_SNAP_LIM: map_sel = SEL_SNAP_LIM;
      OFS_SNAP_BEG: map_sel = SEL_SNAP_BEG;
      OFS_SNAP_END: map_sel = SEL_SNAP_END;
      default:      map_sel = SEL_NONE;
    endcase
  end

  // partial-width accesses are dropped entirely
  assign sel_o = (req_i && full_word) ? map_sel : SEL_NONE;
  assign wr_o  = req_i && full_word && we_i;
  assign rd_o  = req_i && full_word && !we_i;
endmodule

// File: rtl/dma_ctrl_status.sv
module dma_ctrl_status
  import dma_chan_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_ctrl_i,
  input  ctrl_cmd_t cmd_i,
  input  logic      done_evt_i,
  input  logic      chain_evt_i,
  output ctrl_sts_t sts_o
);
  ctrl_sts_t sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    // engine events first, software commands override except on complete
    if (done_evt_i && !chain_evt_i) sts_d.en = 1'b0;
    if (chain_evt_i) sts_d.upd = 1'b0;
    if (wr_ctrl_i) begin
      if (cmd_i.set_en)  sts_d.en  = 1'b1;
      if (cmd_i.set_upd) sts_d.upd = 1'b1;
      if (cmd_i.set_dir) sts_d.dir = 1'b1;
      if (cmd_i.clr_cmp) sts_d.cmp = 1'b0;
      if (cmd_i.rst) begin
        sts_d.en  = 1'b0;
        sts_d.upd = 1'b0;
        sts_d.dir = 1'b0;
        sts_d.cmp = 1'b0;
      end
    end
    // a completion is never lost to a same-cycle clear
    if (done_evt_i) sts_d.cmp = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STEP_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              upd_i,
  input  logic              xfer_i,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] nxt_o,
  output logic [DATA_W-1:0] lim_o,
  output logic [DATA_W-1:0] beg_o,
  output logic [DATA_W-1:0] end_o,
  output logic [DATA_W-1:0] init_o,
  output logic [DATA_W-1:0] snap_o [4],
  output logic              done_evt_o,
  output logic              chain_evt_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(STEP_BYTES);
  localparam int unsigned N_PLAIN = 3;
  localparam int unsigned N_SNAP  = 4;

  logic [DATA_W-1:0] nxt_q, lim_q;
  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] snap_q  [N_SNAP];
  logic [DATA_W-1:0] snap_src [N_SNAP];
  logic              plain_we [N_PLAIN];
  logic [DATA_W-1:0] nxt_inc;
  logic              step, hit;

  assign step    = en_i && xfer_i;
  assign nxt_inc = nxt_q + STEP;
  assign hit     = step && (nxt_inc == lim_q);

  assign done_evt_o  = hit;
  assign chain_evt_o = hit && upd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      lim_q <= '0;
    end else begin
      if (wr_i && sel_i == SEL_NXT)     nxt_q <= wdata_i;
      else if (hit && upd_i)            nxt_q <= plain_q[0];
      else if (step)                    nxt_q <= nxt_inc;

      if (wr_i && sel_i == SEL_LIM)     lim_q <= wdata_i;
      else if (hit && upd_i)            lim_q <= plain_q[1];
    end
  end

  assign plain_we[0] = wr_i && sel_i == SEL_BEG;
  assign plain_we[1] = wr_i && sel_i == SEL_END;
  assign plain_we[2] = wr_i && sel_i == SEL_INIT;

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          plain_q[i] <= '0;
      else if (plain_we[i]) plain_q[i] <= wdata_i;
    end
  end

  assign snap_src[0] = nxt_inc;
  assign snap_src[1] = lim_q;
  assign snap_src[2] = plain_q[0];
  assign snap_src[3] = plain_q[1];

  for (genvar i = 0; i < N_SNAP; i++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  snap_q[i] <= '0;
      else if (hit) snap_q[i] <= snap_src[i];
    end
    assign snap_o[i] = snap_q[i];
  end

  assign nxt_o  = nxt_q;
  assign lim_o  = lim_q;
  assign beg_o  = plain_q[0];
  assign end_o  = plain_q[1];
  assign init_o = plain_q[2];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter  int unsigned DATA_W     = 32,
  parameter  int unsigned STEP_BYTES = 4,
  localparam int unsigned BE_W       = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              xfer_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              wr, rd, wr_ctrl, wr_nxt;
  ctrl_cmd_t         ctrl_cmd;
  ctrl_sts_t         ctrl_sts;
  logic              done_evt, chain_evt;
  logic [DATA_W-1:0] nxt_q, lim_q, beg_q, end_q, init_q;
  logic [DATA_W-1:0] snap [4];
  logic [DATA_W-1:0] ctrl_word, rd_val;

  dma_bus_decode #(.BE_W(BE_W)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .be_i  (be_i),
    .addr_i(addr_i),
    .sel_o (sel),
    .wr_o  (wr),
    .rd_o  (rd)
  );

  assign wr_ctrl = wr && sel == SEL_CTRL;
  assign wr_nxt  = wr && sel == SEL_NXT;

  assign ctrl_cmd.set_en  = wdata_i[CMD_SET_EN];
  assign ctrl_cmd.set_upd = wdata_i[CMD_SET_UPD];
  assign ctrl_cmd.set_dir = wdata_i[CMD_SET_DIR];
  assign ctrl_cmd.clr_cmp = wdata_i[CMD_CLR_CMP];
  assign ctrl_cmd.rst     = wdata_i[CMD_RST];

  dma_ctrl_status u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .cmd_i      (ctrl_cmd),
    .done_evt_i (done_evt),
    .chain_evt_i(chain_evt),
    .sts_o      (ctrl_sts)
  );

  dma_xfer_engine #(.DATA_W(DATA_W), .STEP_BYTES(STEP_BYTES)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_sts.en),
    .upd_i      (ctrl_sts.upd),
    .xfer_i     (xfer_i),
    .wr_i       (wr),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .nxt_o      (nxt_q),
    .lim_o      (lim_q),
    .beg_o      (beg_q),
    .end_o      (end_q),
    .init_o     (init_q),
    .snap_o     (snap),
    .done_evt_o (done_evt),
    .chain_evt_o(chain_evt)
  );

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[STS_EN]  = ctrl_sts.en;
    ctrl_word[STS_UPD] = ctrl_sts.upd;
    ctrl_word[STS_DIR] = ctrl_sts.dir;
    ctrl_word[STS_CMP] = ctrl_sts.cmp;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:     rd_val = ctrl_word;
      SEL_NXT:      rd_val = nxt_q;
      SEL_LIM:      rd_val = lim_q;
      SEL_BEG:      rd_val = beg_q;
      SEL_END:      rd_val = end_q;
      SEL_INIT:     rd_val = init_q;
      SEL_SIZE:     rd_val = lim_q - nxt_q;
      SEL_SNAP_NXT: rd_val = snap[0];
      SEL_SNAP_LIM: rd_val = snap[1];
      SEL_SNAP_BEG: rd_val = snap[2];
      SEL_SNAP_END: rd_val = snap[3];
      default:      rd_val = '0;
    endcase
  end

  assign rdata_o = rd ? rd_val : '0;
  assign irq_o   = ctrl_sts.cmp;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STEP_BYTES = 4,
  parameter int unsigned BE_W       = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [BE_W-1:0]   be_i,
  input logic              xfer_i,
  input logic              irq_o,
  input logic              st_en_i,
  input logic              st_upd_i,
  input logic              wr_ctrl_i,
  input logic              wr_nxt_i,
  input ctrl_cmd_t         cmd_i,
  input logic [DATA_W-1:0] nxt_i,
  input logic [DATA_W-1:0] lim_i,
  input logic [DATA_W-1:0] rdata_i
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(STEP_BYTES);

  assert_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_en_i && xfer_i && !wr_nxt_i && (nxt_i + STEP != lim_i))
      |=> nxt_i == $past(nxt_i) + STEP);

  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(xfer_i) && $past(st_en_i));

  assert_clear_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && cmd_i.clr_cmp && !(st_en_i && xfer_i)) |=> !irq_o);

  assert_set_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && cmd_i.set_en && !cmd_i.rst) |=> st_en_i);

  assert_chain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_en_i && st_upd_i && xfer_i && !wr_ctrl_i && (nxt_i + STEP == lim_i))
      |=> (st_en_i && !st_upd_i && irq_o));

  assert_partial_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(&be_i)) |-> rdata_i == '0);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .DATA_W(DATA_W), .STEP_BYTES(STEP_BYTES), .BE_W(BE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .be_i     (be_i),
  .xfer_i   (xfer_i),
  .irq_o    (irq_o),
  .st_en_i  (ctrl_sts.en),
  .st_upd_i (ctrl_sts.upd),
  .wr_ctrl_i(wr_ctrl),
  .wr_nxt_i (wr_nxt),
  .cmd_i    (ctrl_cmd),
  .nxt_i    (nxt_q),
  .lim_i    (lim_q),
  .rdata_i  (rdata_o)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  localparam int CLK_P = 10;

  localparam logic [14:0] A_CTRL = 15'h0000, A_NXT = 15'h4000, A_LIM = 15'h4004,
                          A_BEG = 15'h4008, A_END = 15'h400C, A_INIT = 15'h4200,
                          A_SIZE = 15'h4204, A_SN = 15'h3FF0, A_SL = 15'h3FF4,
                          A_SB = 15'h3FF8, A_SE = 15'h3FFC, A_HOLE = 15'h0100;
  localparam logic [31:0] C_EN = 32'h1 << 16, C_UPD = 32'h1 << 17, C_DIR = 32'h1 << 18,
                          C_CLR = 32'h1 << 19, C_RST = 32'h1 << 20;
  localparam logic [31:0] S_DIR = 32'h1 << 18, S_EN = 32'h1 << 24, S_UPD = 32'h1 << 25,
                          S_CMP = 32'h1 << 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, xfer = 1'b0;
  logic [3:0]  be = 4'hF;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .xfer_i(xfer), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic rd_chk(input logic [14:0] a, input logic [31:0] exp, input string tag,
                        input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    #1 check(tag, rdata, exp);
    req = 1'b0; be = 4'hF;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer = 1'b1;
      @(negedge clk); xfer = 1'b0;
    end
  endtask

  task automatic wr_with_xfer(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; xfer = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; xfer = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(A_CTRL, 32'h0, "R1 ctrl after reset");
    rd_chk(A_NXT, 32'h0, "R1 next after reset");
    rd_chk(A_SN, 32'h0, "R1 snapshot after reset");
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    wr(A_NXT, 32'h1000); wr(A_LIM, 32'h100C);
    wr(A_BEG, 32'h5000); wr(A_END, 32'h5020); wr(A_INIT, 32'hABCD0000);
    rd_chk(A_NXT, 32'h1000, "R7 next");
    rd_chk(A_LIM, 32'h100C, "R7 limit");
    rd_chk(A_BEG, 32'h5000, "R7 start");
    rd_chk(A_END, 32'h5020, "R7 stop");
    rd_chk(A_INIT, 32'hABCD0000, "R7 initial buffer");
    rd_chk(A_SIZE, 32'h0000000C, "R13 size");
    wr(A_SN, 32'hDEAD);
    rd_chk(A_SN, 32'h0, "R7 snapshot ignores write");
  endtask

  task automatic t_partial;
    wr(A_NXT, 32'h7777, 4'h3);
    rd_chk(A_NXT, 32'h1000, "R8 partial write ignored");
    rd_chk(A_NXT, 32'h0, "R8 partial read zero", 4'h1);
    wr(A_HOLE, 32'h1234);
    rd_chk(A_HOLE, 32'h0, "R8 unmapped reads zero");
  endtask

  task automatic t_cmds;
    wr(A_CTRL, C_DIR);
    rd_chk(A_CTRL, S_DIR, "R4 direction set");
    wr(A_CTRL, 32'h0);
    rd_chk(A_CTRL, S_DIR, "R4 zero leaves direction");
    wr(A_CTRL, C_UPD);
    rd_chk(A_CTRL, S_DIR | S_UPD, "R3 chain update set");
    wr(A_CTRL, C_RST);
    rd_chk(A_CTRL, 32'h0, "R6 reset clears");
    wr(A_CTRL, C_RST | C_EN);
    rd_chk(A_CTRL, 32'h0, "R6 reset beats set-enable");
  endtask

  task automatic t_engine;
    pulse(1);
    rd_chk(A_NXT, 32'h1000, "R9 strobe without enable");
    wr(A_CTRL, C_EN);
    rd_chk(A_CTRL, S_EN, "R2 enable set");
    pulse(1);
    rd_chk(A_NXT, 32'h1004, "R9 step by 4");
    rd_chk(A_SIZE, 32'h8, "R13 size after step");
    pulse(2);
    rd_chk(A_NXT, 32'h100C, "R10 next at limit");
    rd_chk(A_CTRL, S_CMP, "R10 complete set enable cleared");
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    rd_chk(A_SN, 32'h100C, "R10 snapshot next");
    rd_chk(A_SL, 32'h100C, "R10 snapshot limit");
    rd_chk(A_SB, 32'h5000, "R10 snapshot start");
    rd_chk(A_SE, 32'h5020, "R10 snapshot stop");
    pulse(1);
    rd_chk(A_NXT, 32'h100C, "R9 halted after completion");
    wr(A_CTRL, C_CLR);
    rd_chk(A_CTRL, 32'h0, "R5 complete cleared");
    check("R5 irq dropped", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_chain;
    wr(A_NXT, 32'h2000); wr(A_LIM, 32'h2008);
    wr(A_BEG, 32'h3000); wr(A_END, 32'h3010);
    wr(A_CTRL, C_EN | C_UPD);
    pulse(2);
    rd_chk(A_NXT, 32'h3000, "R11 next reloaded");
    rd_chk(A_LIM, 32'h3010, "R11 limit reloaded");
    rd_chk(A_CTRL, S_EN | S_CMP, "R11 still enabled, update cleared");
    rd_chk(A_SN, 32'h2008, "R11 snapshot of finished buffer");
  endtask

  task automatic t_collide;
    pulse(3);
    rd_chk(A_NXT, 32'h300C, "R9 steps in reloaded buffer");
    wr_with_xfer(A_CTRL, C_CLR);
    rd_chk(A_CTRL, S_CMP, "R12 completion beats clear");
    check("R12 irq kept", {31'h0, irq}, 32'h1);
    wr(A_NXT, 32'h4000); wr(A_LIM, 32'h4100);
    wr(A_CTRL, C_EN | C_CLR);
    rd_chk(A_CTRL, S_EN, "R2 re-enabled");
    wr_with_xfer(A_NXT, 32'h4800);
    rd_chk(A_NXT, 32'h4800, "R12 bus write beats step");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_partial();
    t_cmds();
    t_engine();
    t_chain();
    t_collide();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule